// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block receives words from a serial link on which an external master drives both the shift clock and the data line. Both lines are brought into the system clock domain through two-flop synchronizers. A falling edge of the synchronized shift clock takes one data bit, and bits arrive least significant first. When the last bit of a word has arrived, the assembled word is copied into a receive buffer and a completion flag is raised. An interrupt request follows that flag when the interrupt enable is set.

Software sets up reception through a control register on a small register bus. The receiver has an 8-bit and a 9-bit word mode. In 9-bit mode the top bit is read from a status register, apart from the data byte. Reception runs only while the link is configured as a continuously receiving slave. If a word completes while the previous word has not been read, the receiver latches an overrun error, throws the new word away and accepts no more words. Clearing the continuous-receive enable is the only way to clear that error.

The receive path needs no register access while it runs. A word can complete while nothing else in the system is active.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00 and `irq_o` is low.
- R2: Words are received only while the control register has port enable (bit 0), sync select (bit 1) and continuous enable (bit 3) set and clock-master select (bit 2) clear. Otherwise shift clock edges leave the status register at 0x00 and leave the buffer unchanged.
- R3: The single-receive bit (control bit 4) has no effect. With it set and continuous enable clear, nothing is received. With it set in addition to a valid setup, reception is the same as without it.
- R4: Each falling edge of `sclk_i` takes `sdata_i`, least significant bit first. In 8-bit mode the eighth bit completes the word. The word then reads from the data register (address 2), and status bit 2 (done) is set.
- R5: `irq_o` is high exactly while done is set and interrupt enable (control bit 6) is set.
- R6: With 9-bit mode set (control bit 5), a word completes on the ninth bit. Its ninth bit reads as status bit 0, and the low eight bits read from the data register. In 8-bit mode, status bit 0 reads 0.
- R7: A read of the data register clears done. A read of the status register does not change done.
- R8: If a word completes while done is set, status bit 1 (overrun) is set and the buffer keeps the earlier word. While overrun is set, later words are discarded.
- R9: Clearing continuous enable clears overrun. After it is set again, words are received normally.
- R10: If reception is disabled partway through a word, the partial bits are dropped. The next word, after reception is enabled again, is assembled from its own bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Shift clock driven by the external master |
| sdata_i | input | 1 | Serial data driven by the external master |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (address 0 only) |
| bus_rd | input | 1 | Read strobe, needed for the data-read side effect |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 7 | Control write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest situation to reach is the overrun path. A second complete word must arrive while the first word is still unread, and then a third word must be seen to be discarded. The error must also be seen to survive everything except a drop of continuous enable. The stimulus reaches it by sending words back to back with no data read between them, checking the status and buffer after each word. It then clears and sets continuous enable and sends one more word. A mid-word disable case covers a stale bit counter, and random words in both word lengths cover bit ordering.

// File: rtl/sync_slave_rx_pkg.sv
package sync_slave_rx_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_W       = 7;
  localparam int C_PORT_EN    = 0;
  localparam int C_SYNC       = 1;
  localparam int C_MASTER     = 2;
  localparam int C_CONT       = 3;
  localparam int C_SINGLE     = 4;
  localparam int C_NINE       = 5;
  localparam int C_INT_EN     = 6;

  localparam int S_NINTH      = 0;
  localparam int S_OVR        = 1;
  localparam int S_DONE       = 2;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          nine_i,
  input  logic          sclk_s_i,
  input  logic          sdata_s_i,
  output logic          word_done_o,
  output logic [DATA_W:0] word_o
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(DATA_W);

  logic              prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W:0]   sh_q, sh_d;
  logic              done_q, done_d;
  logic              fall;
  logic [CNT_W-1:0]  last;

  always_comb begin
    fall   = prev_q & ~sclk_s_i;
    last   = nine_i ? LAST9 : LAST8;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (!active_i) begin
      cnt_d = '0;
    end else if (fall) begin
      if (cnt_q == '0) sh_d = '0;
      sh_d[cnt_q] = sdata_s_i;
      if (cnt_q == last) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      prev_q <= sclk_s_i;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign word_done_o = done_q;
  assign word_o      = sh_q;

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST9);
  assert_idle_clears_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> cnt_q == '0);
  assert_done_needs_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_done_o |-> $past(active_i));
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import sync_slave_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              word_done_i,
  input  logic [DATA_W:0]   word_i,
  output logic              active_o,
  output logic              nine_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W:0]   buf_q, buf_d;
  logic              done_q, done_d;
  logic              ovr_q, ovr_d;
  logic              wr_ctrl, rd_data, full;

  always_comb begin
    wr_ctrl = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
    rd_data = bus_sel & bus_rd & (bus_addr == ADDR_DATA);
    full    = done_q & ~rd_data;
    ctrl_d  = wr_ctrl ? bus_wdata : ctrl_q;
    buf_d   = buf_q;
    done_d  = done_q;
    ovr_d   = ovr_q;
    if (rd_data) done_d = 1'b0;
    if (word_done_i) begin
      if (ovr_q) begin
        ovr_d = 1'b1;
      end else if (full) begin
        ovr_d = 1'b1;
      end else begin
        buf_d  = ctrl_q[C_NINE] ? word_i : {1'b0, word_i[DATA_W-1:0]};
        done_d = 1'b1;
      end
    end
    if (!ctrl_q[C_CONT]) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      buf_q  <= buf_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_STAT: begin
        bus_rdata[S_NINTH] = buf_q[DATA_W];
        bus_rdata[S_OVR]   = ovr_q;
        bus_rdata[S_DONE]  = done_q;
      end
      ADDR_DATA: bus_rdata = buf_q[DATA_W-1:0];
      default:   bus_rdata = '0;
    endcase
  end

  assign active_o = ctrl_q[C_PORT_EN] & ctrl_q[C_SYNC] & ~ctrl_q[C_MASTER] & ctrl_q[C_CONT];
  assign nine_o   = ctrl_q[C_NINE];
  assign irq_o    = done_q & ctrl_q[C_INT_EN];

  assert_buf_moves_only_on_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done_i |=> $stable(buf_q));
  assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(done_q) && $past(word_done_i));
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && ctrl_q[C_CONT] && !wr_ctrl |=> ovr_q);
  assert_overrun_keeps_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> $stable(buf_q));
  assert_data_read_clears_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !word_done_i |=> !done_q);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_slave_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_s;
  logic               active;
  logic               nine;
  logic               word_done;
  logic [DATA_W:0]    word;

  assign line_raw = {sdata_i, sclk_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (line_raw[g]),
      .q_o  (line_s[g])
    );
  end

  rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .nine_i     (nine),
    .sclk_s_i   (line_s[0]),
    .sdata_s_i  (line_s[1]),
    .word_done_o(word_done),
    .word_o     (word)
  );

  rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .word_done_i(word_done),
    .word_i     (word),
    .active_o   (active),
    .nine_o     (nine),
    .irq_o      (irq_o)
  );

  assert_irq_follows_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (bus_addr != ADDR_CTRL) || bus_rdata[C_INT_EN]);
endmodule

// File: tb/sync_slave_rx_bench.sv
`timescale 1ns/100ps
module sync_slave_rx_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic sclk_i, sdata_i;
  logic bus_sel, bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [6:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rv;

  localparam logic [6:0] RXON = 7'h0B;

  always #2.5 clk = ~clk;

  sync_slave_rx u_sync_slave_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_stat(input logic ninth, input logic ovr, input logic done);
    return {5'b0, done, ovr, ninth};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0; bus_addr = 2'd1;
  endtask

  task automatic send_bits(input logic [8:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdata_i = w[i];
      repeat (4) @(negedge clk);
      sclk_i = 0;
      repeat (4) @(negedge clk);
      sclk_i = 1;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [8:0] w;
    logic nine;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 0; sclk_i = 1; sdata_i = 0;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 2'd1; bus_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rv); check("R1 ctrl", rv, 8'h00);
    bus_read(2'd1, rv); check("R1 stat", rv, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);

    // R2 disabled setups ignore shift clock
    bus_write(2'd0, RXON | 7'h04);
    send_bits(9'h0A5, 8);
    bus_read(2'd1, rv); check("R2 master set", rv, 8'h00);
    bus_write(2'd0, 7'h0A);
    send_bits(9'h03C, 8);
    bus_read(2'd1, rv); check("R2 no port", rv, 8'h00);
    bus_write(2'd0, 7'h09);
    send_bits(9'h03C, 8);
    bus_read(2'd1, rv); check("R2 no sync", rv, 8'h00);
    bus_read(2'd2, rv); check("R2 buf unchanged", rv, 8'h00);

    // R3 single enable without continuous
    bus_write(2'd0, 7'h13);
    send_bits(9'h0FF, 8);
    bus_read(2'd1, rv); check("R3 single only", rv, 8'h00);

    // R3 and R4 with single enable added, LSB first
    bus_write(2'd0, RXON | 7'h10);
    send_bits(9'h0B4, 8);
    bus_read(2'd1, rv); check("R4 done set", rv, exp_stat(0, 0, 1));
    bus_read(2'd1, rv); check("R7 stat read keeps done", rv, exp_stat(0, 0, 1));
    bus_read(2'd2, rv); check("R3 R4 data", rv, 8'hB4);
    bus_read(2'd1, rv); check("R7 done cleared", rv, exp_stat(0, 0, 0));

    // R5 interrupt
    bus_write(2'd0, RXON);
    send_bits(9'h011, 8);
    check("R5 irq off no enable", {7'b0, irq_o}, 8'h00);
    bus_write(2'd0, RXON | 7'h40);
    check("R5 irq on", {7'b0, irq_o}, 8'h01);
    bus_read(2'd2, rv); check("R5 data", rv, 8'h11);
    check("R5 irq cleared", {7'b0, irq_o}, 8'h00);

    // R6 nine-bit
    bus_write(2'd0, RXON | 7'h20);
    send_bits(9'h1C3, 8);
    bus_read(2'd1, rv); check("R6 not done at 8", rv, exp_stat(0, 0, 0));
    send_bits(9'h1C3 >> 8, 1);
    bus_read(2'd1, rv); check("R6 ninth", rv, exp_stat(1, 0, 1));
    bus_read(2'd2, rv); check("R6 data", rv, 8'hC3);

    // R10 partial word dropped
    bus_write(2'd0, RXON);
    send_bits(9'h007, 3);
    bus_write(2'd0, 7'h03);
    bus_write(2'd0, RXON);
    send_bits(9'h05A, 8);
    bus_read(2'd1, rv); check("R10 done", rv, exp_stat(0, 0, 1));
    bus_read(2'd2, rv); check("R10 data", rv, 8'h5A);

    // R8 overrun
    send_bits(9'h0AA, 8);
    send_bits(9'h055, 8);
    bus_read(2'd1, rv); check("R8 overrun", rv, exp_stat(0, 1, 1));
    bus_read(2'd2, rv); check("R8 old word kept", rv, 8'hAA);
    send_bits(9'h0F0, 8);
    bus_read(2'd1, rv); check("R8 still overrun", rv, exp_stat(0, 1, 0));
    bus_read(2'd2, rv); check("R8 discarded", rv, 8'hAA);

    // R9 clear by dropping continuous enable
    bus_write(2'd0, 7'h03);
    bus_read(2'd1, rv); check("R9 cleared", rv, exp_stat(0, 0, 0));
    bus_write(2'd0, RXON);
    send_bits(9'h096, 8);
    bus_read(2'd1, rv); check("R9 resume", rv, exp_stat(0, 0, 1));
    bus_read(2'd2, rv); check("R9 data", rv, 8'h96);

    // R4 R6 random words
    for (int i = 0; i < 24; i++) begin
      nine = 1'($urandom % 2);
      w = 9'($urandom);
      if (!nine) w[8] = 1'b0;
      bus_write(2'd0, RXON | (nine ? 7'h20 : 7'h00));
      send_bits(w, nine ? 9 : 8);
      bus_read(2'd1, rv); check("R6 rand stat", rv, exp_stat(w[8], 0, 1));
      bus_read(2'd2, rv); check("R4 rand data", rv, w[7:0]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule